// File: doc/BRIEF.md
# Byte-Wide SPI Master with Auto-Transmit

This block is a byte-oriented SPI master working in clock mode 0. A host drives it through two byte-wide registers on a simple strobed register bus: a data register and a control register. Writing the data register while the engine is idle starts an 8-bit full-duplex transfer. Reading the data register returns the byte received by the last completed transfer. The control register drives the active-low chip-select line, picks a fast or a slow serial clock and enables auto-transmit. It also reports a busy flag.

With auto-transmit enabled, each read of the data register returns the previously received byte. In the same cycle it starts a new transfer that sends all ones (0xFF). A host can therefore stream bytes in from a device, such as a memory card, with one register read per byte. The slow clock suits cards that need a low clock rate during initialisation. The fast clock is used for bulk data.

Register map (address `reg_addr`): 0 = data, 1 = control. Control bits: bit 0 `sel` (1 asserts chip select), bit 1 `slow` (1 selects the slow clock), bit 2 `auto_tx` (1 enables auto-transmit), bit 7 `busy` (read only), bits 6:3 read as 0.

Top module: `spi_byte_master`

## Requirements
- R1: After reset `spi_sck` is 0, `spi_cs_n` is 1, the control register reads 0x00 and the data register reads 0x00.
- R2: `spi_cs_n` equals the inverse of control bit 0 from the clock edge that registers a control write onward.
- R3: A data write (address 0) while idle starts a transfer. Control bit 7 reads 1 for exactly 8 × the selected divider cycles, beginning with the cycle after the write.
- R4: The byte goes out on `spi_mosi` MSB first. MOSI changes only at the start of a transfer or while SCK falls. SCK is 0 whenever no transfer is running.
- R5: MISO is sampled on each rising SCK edge, MSB first. After completion the data register reads the received byte.
- R6: With control bit 1 = 0 one SCK period is FAST_DIV (default 4) clock cycles. With bit 1 = 1 it is SLOW_DIV (default 128) cycles.
- R7: A data write while busy is ignored. The byte in flight and the transfer length stay unchanged.
- R8: With control bit 2 = 1, a data read while idle returns the previously received byte and starts a transfer that sends 0xFF.
- R9: With control bit 2 = 0, a data read starts no transfer (control bit 7 stays 0).
- R10: The control register reads back bits 2:0 as written, bits 6:3 as 0 and bit 7 as the busy flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz nominal) |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 1 | Register select: 0 data, 1 control |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register, combinational |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The bench sends every one of the 256 byte values at the fast rate while a modelled device returns a different pattern. A design that shifted LSB first, sampled on the wrong edge or dropped a bit would corrupt either the device's capture or the read-back byte. The busy length is counted cycle by cycle at both rates, so an off-by-one in the half-period counter or the bit counter shows up as a wrong count. Further cases write the data register in the middle of a transfer and read the data register with auto-transmit both on and off. A design that restarted on the intruding write, returned the new byte too early or launched a transfer without auto-transmit fails these.

// File: rtl/spi_pkg.sv
package spi_pkg;

    localparam logic ADDR_DATA = 1'b0;
    localparam logic ADDR_CTRL = 1'b1;

    localparam int CTRL_SEL_BIT  = 0;
    localparam int CTRL_SLOW_BIT = 1;
    localparam int CTRL_AUTO_BIT = 2;
    localparam int CTRL_BUSY_BIT = 7;

    localparam logic [7:0] AUTO_FILL = 8'hFF;

    typedef struct packed {
        logic auto_tx;
        logic slow;
        logic sel;
    } ctrl_t;

endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
    parameter int FAST_DIV = 4,
    parameter int SLOW_DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic slow_i,
    output logic tick_o
);
    localparam int FAST_HALF = FAST_DIV / 2;
    localparam int SLOW_HALF = SLOW_DIV / 2;
    localparam int MAX_HALF  = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
    localparam int CW        = (MAX_HALF > 1) ? $clog2(MAX_HALF) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } rate_t;

    rate_t s_q, s_d;
    logic [CW-1:0] limit;

    always_comb begin
        limit  = slow_i ? CW'(SLOW_HALF - 1) : CW'(FAST_HALF - 1);
        tick_o = run_i && (s_q.cnt >= limit);
        s_d    = s_q;
        if (!run_i || tick_o) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R6: half periods span at least two cycles, never back-to-back ticks
    p_tick_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    // R6: counter resets when the engine is idle
    p_idle_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (s_q.cnt == '0));

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [BITS-1:0] tx_byte_i,
    input  logic            tick_i,
    input  logic            miso_i,
    output logic            busy_o,
    output logic            sck_o,
    output logic            mosi_o,
    output logic [BITS-1:0] rx_byte_o
);
    localparam int CNT_W = (BITS > 1) ? $clog2(BITS) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BITS - 1);

    typedef struct packed {
        logic            busy;
        logic            sck;
        logic [CNT_W-1:0] cnt;
        logic [BITS-1:0] tx;
        logic [BITS-1:0] rx_sh;
        logic [BITS-1:0] rx_last;
    } eng_t;

    eng_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (!s_q.busy) begin
            s_d.sck = 1'b0;
            if (start_i) begin
                s_d.busy = 1'b1;
                s_d.cnt  = '0;
                s_d.tx   = tx_byte_i;
            end
        end else if (tick_i) begin
            if (!s_q.sck) begin
                s_d.sck   = 1'b1;
                s_d.rx_sh = {s_q.rx_sh[BITS-2:0], miso_i};
            end else begin
                s_d.sck = 1'b0;
                if (s_q.cnt == LAST_BIT) begin
                    s_d.busy    = 1'b0;
                    s_d.rx_last = s_q.rx_sh;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                    s_d.tx  = {s_q.tx[BITS-2:0], 1'b1};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o    = s_q.busy;
    assign sck_o     = s_q.sck;
    assign mosi_o    = s_q.tx[BITS-1];
    assign rx_byte_o = s_q.rx_last;

    // R4: clock idles low outside a transfer
    p_sck_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.busy |-> !s_q.sck);

    // R4: MOSI only moves on a falling SCK within a transfer
    p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && $past(s_q.busy) && !$fell(s_q.sck)) |-> $stable(mosi_o));

    // R3: a transfer ends only after the last bit's falling edge
    p_done_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.busy) |-> ($past(s_q.cnt) == LAST_BIT && $past(s_q.sck)));

    // R7: a start request during a transfer leaves the byte in flight alone
    p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && start_i && !tick_i) |=> $stable(s_q.tx));

endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file
    import spi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    input  logic       busy_i,
    input  logic [7:0] rx_byte_i,
    output logic [7:0] reg_rdata,
    output ctrl_t      ctrl_o,
    output logic       start_o,
    output logic [7:0] tx_byte_o
);
    typedef struct packed {
        ctrl_t ctrl;
    } regs_t;

    regs_t s_q, s_d;
    logic  data_wr;
    logic  auto_rd;

    always_comb begin
        s_d = s_q;
        if (reg_wr && reg_addr == ADDR_CTRL) begin
            s_d.ctrl.sel     = reg_wdata[CTRL_SEL_BIT];
            s_d.ctrl.slow    = reg_wdata[CTRL_SLOW_BIT];
            s_d.ctrl.auto_tx = reg_wdata[CTRL_AUTO_BIT];
        end

        data_wr   = reg_wr && (reg_addr == ADDR_DATA) && !busy_i;
        auto_rd   = reg_rd && !reg_wr && (reg_addr == ADDR_DATA)
                    && s_q.ctrl.auto_tx && !busy_i;
        start_o   = data_wr || auto_rd;
        tx_byte_o = data_wr ? reg_wdata : AUTO_FILL;

        reg_rdata = '0;
        if (reg_addr == ADDR_CTRL) begin
            reg_rdata[CTRL_SEL_BIT]  = s_q.ctrl.sel;
            reg_rdata[CTRL_SLOW_BIT] = s_q.ctrl.slow;
            reg_rdata[CTRL_AUTO_BIT] = s_q.ctrl.auto_tx;
            reg_rdata[CTRL_BUSY_BIT] = busy_i;
        end else begin
            reg_rdata = rx_byte_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl_o = s_q.ctrl;

    // R2: select follows a control write from the next edge
    p_sel_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_CTRL) |=> (ctrl_o.sel == $past(reg_wdata[CTRL_SEL_BIT])));

    // R7: no start request while busy
    p_no_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> !start_o);

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
    import spi_pkg::*;
#(
    parameter int FAST_DIV = 4,
    parameter int SLOW_DIV = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       spi_sck,
    output logic       spi_mosi,
    input  logic       spi_miso,
    output logic       spi_cs_n
);
    ctrl_t      ctrl;
    logic       start;
    logic [7:0] tx_byte;
    logic       busy;
    logic       tick;
    logic [7:0] rx_byte;

    spi_reg_file u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .busy_i    (busy),
        .rx_byte_i (rx_byte),
        .reg_rdata (reg_rdata),
        .ctrl_o    (ctrl),
        .start_o   (start),
        .tx_byte_o (tx_byte)
    );

    spi_rate_gen #(
        .FAST_DIV (FAST_DIV),
        .SLOW_DIV (SLOW_DIV)
    ) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy),
        .slow_i (ctrl.slow),
        .tick_o (tick)
    );

    spi_shift_engine #(
        .BITS (8)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .tx_byte_i (tx_byte),
        .tick_i    (tick),
        .miso_i    (spi_miso),
        .busy_o    (busy),
        .sck_o     (spi_sck),
        .mosi_o    (spi_mosi),
        .rx_byte_o (rx_byte)
    );

    assign spi_cs_n = ~ctrl.sel;

    // R8: an auto-transmit read while idle launches a transfer
    p_auto_launch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && reg_addr == ADDR_DATA && ctrl.auto_tx && !busy) |=> busy);

    // R9: a plain read never launches a transfer
    p_plain_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && !ctrl.auto_tx && !busy) |=> !busy);

endmodule

// File: tb/spi_byte_master_tb_top.sv
`timescale 1ns/1ps
module spi_byte_master_tb_top;
    localparam int FAST_DIV = 4;
    localparam int SLOW_DIV = 128;
    localparam int CLK_NS   = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_addr = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       spi_sck;
    logic       spi_mosi;
    logic       spi_miso;
    logic       spi_cs_n;

    int checks = 0;
    int errors = 0;

    always #(CLK_NS / 2) clk = ~clk;

    spi_byte_master #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .spi_sck   (spi_sck),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .spi_cs_n  (spi_cs_n)
    );

    // device model: drives MISO MSB first, shifts on falling SCK, captures MOSI on rising SCK
    int         fall_cnt = 0;
    int         base_cnt = 0;
    logic [7:0] slave_byte = 8'h00;
    logic [7:0] slave_rx = 8'h00;
    time        last_rise = 0;
    time        prev_rise = 0;

    always @(negedge spi_sck) fall_cnt <= fall_cnt + 1;
    always @(posedge spi_sck) begin
        slave_rx  <= {slave_rx[6:0], spi_mosi};
        prev_rise <= last_rise;
        last_rise <= $time;
    end
    always_comb begin
        int idx;
        idx = fall_cnt - base_cnt;
        spi_miso = (idx >= 0 && idx < 8) ? slave_byte[3'(7 - idx)] : 1'b0;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] v);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // count cycles the busy flag reads 1; optionally write data at one polled cycle
    task automatic poll_busy(input int intrude, input logic [7:0] iv, output int n);
        logic [7:0] v;
        n = 0;
        for (int k = 0; k < 4000; k++) begin
            if (k == intrude) begin
                wr(1'b0, iv);
                n++;
            end else begin
                rd(1'b1, v);
                if (!v[7]) break;
                n++;
            end
        end
    endtask

    task automatic xfer(input logic [7:0] tx, input logic [7:0] slv, input int div,
                        input int intrude, input logic [7:0] iv, input bit full);
        int n;
        logic [7:0] v;
        base_cnt   = fall_cnt;
        slave_byte = slv;
        wr(1'b0, tx);
        poll_busy(intrude, iv, n);
        if (full) check("R3 busy length", n, 8 * div);
        check("R4 MOSI byte", slave_rx, tx);
        if (full) check("R6 SCK period", int'((last_rise - prev_rise) / CLK_NS), div);
        check("R4 SCK idle", spi_sck, 0);
        rd(1'b0, v);
        check("R5 MISO byte", v, slv);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 sck", spi_sck, 0);
        check("R1 cs_n", spi_cs_n, 1);
        rd(1'b1, v); check("R1 ctrl", v, 8'h00);
        rd(1'b0, v); check("R1 data", v, 8'h00);

        // R2 select line
        wr(1'b1, 8'h01);
        check("R2 cs asserted", spi_cs_n, 0);
        wr(1'b1, 8'h00);
        check("R2 cs released", spi_cs_n, 1);
        wr(1'b1, 8'h01);

        // R10 readback: bits 6:3 ignored, bit 7 read-only
        wr(1'b1, 8'hFB);
        rd(1'b1, v); check("R10 ctrl readback", v, 8'h03);
        wr(1'b1, 8'h01);
        rd(1'b1, v); check("R10 ctrl readback", v, 8'h01);

        // R3 R4 R5 R6 exhaustive fast sweep
        for (int t = 0; t < 256; t++) begin
            xfer(8'(t), 8'(~t ^ (t << 3)), FAST_DIV, -1, 8'h00, 1'b1);
        end

        // R6 slow rate
        wr(1'b1, 8'h03);
        xfer(8'hC3, 8'h5A, SLOW_DIV, -1, 8'h00, 1'b1);
        xfer(8'h01, 8'h80, SLOW_DIV, -1, 8'h00, 1'b1);
        wr(1'b1, 8'h01);

        // R7 write in mid transfer is ignored
        xfer(8'hA5, 8'h3C, FAST_DIV, 7, 8'h0F, 1'b1);
        xfer(8'h96, 8'h69, FAST_DIV, 0, 8'hFF, 1'b1);

        // R9 plain read starts nothing
        rd(1'b0, v); check("R9 data unchanged", v, 8'h69);
        rd(1'b1, v); check("R9 no busy", v[7], 0);

        // R8 auto-transmit read
        wr(1'b1, 8'h05);
        base_cnt   = fall_cnt;
        slave_byte = 8'hE7;
        rd(1'b0, v); check("R8 returns previous", v, 8'h69);
        poll_busy(-1, 8'h00, n);
        check("R8 auto busy length", n, 8 * FAST_DIV);
        check("R8 sends fill", slave_rx, 8'hFF);
        wr(1'b1, 8'h01);
        rd(1'b0, v); check("R8 new byte", v, 8'hE7);
        rd(1'b1, v); check("R8 no rearm without auto", v[7], 0);

        // R8 auto mode at slow rate, second read streams next byte
        wr(1'b1, 8'h07);
        base_cnt   = fall_cnt;
        slave_byte = 8'h12;
        rd(1'b0, v); check("R8 slow previous", v, 8'hE7);
        poll_busy(-1, 8'h00, n);
        check("R8 slow busy length", n, 8 * SLOW_DIV);
        base_cnt   = fall_cnt;
        slave_byte = 8'h34;
        rd(1'b0, v); check("R8 stream previous", v, 8'h12);
        poll_busy(-1, 8'h00, n);
        check("R8 stream busy length", n, 8 * SLOW_DIV);
        wr(1'b1, 8'h00);
        rd(1'b0, v); check("R8 stream byte", v, 8'h34);
        check("R2 cs released end", spi_cs_n, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule